// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A one-byte holding buffer sits in front of a frame shifter, so software (or an upstream stream source) can queue the next byte while the current frame is still on the line. Writing into the buffer is the only thing needed to start a transmission. There is no separate start command.

Bit timing comes from an external baud tick. Every bit lasts a fixed number of ticks, 16 by default. Plain control inputs select 7- or 8-bit data, parity on or off, parity sense and one or two stop bits. These settings are taken at the moment a frame starts. The transmit enable gates the tick into the shifter. Enable may only change while the block is idle.

The write side is a valid/ready stream. Ready is held high at all times, so no back-pressure is ever applied. A write accepted while the buffer still holds a byte replaces that byte. Upstream logic should therefore wait for buffer-empty before sending the next byte if no byte may be lost.

Top module: `sertx_top`

## Requirements
- R1: After reset the line `txd` is 1, `buf_empty` is 1, `tx_busy` is 0 and `wr_ready` is 1.
- R2: A write (`wr_valid`=1 at a clock edge) is always accepted and makes `buf_empty` 0 in the next cycle. A write that arrives while the buffer is full replaces the buffered byte and leaves the frame on the line unchanged.
- R3: A frame begins at a baud tick when enable is 1 and the buffer is full. The byte moves into the shifter at that edge, so `buf_empty` rises in the same cycle that `txd` drops to the start bit.
- R4: A frame is sent in this order: a start bit of 0, the data bits least significant first, the parity bit if enabled, then the stop bits of 1. Each bit lasts 16 baud ticks, and `txd` changes only at edges where `baud_tick` is 1.
- R5: With `len7`=1, only bits 6..0 of the byte are sent. Bit 7 has no effect on the data bits or on parity.
- R6: With `par_en`=1, a parity bit follows the data. With `par_odd`=0, the count of ones over the data bits plus the parity bit is even. With `par_odd`=1, that count is odd. With `par_en`=0, no parity bit is sent.
- R7: `stop2`=0 gives one stop bit and `stop2`=1 gives two stop bits.
- R8: `tx_busy` is 1 from the start bit until the end of the last stop bit. When a byte is waiting at the end of a frame, its start bit follows the last stop bit directly, and `tx_busy` stays 1 with no gap between frames.
- R9: While `tx_en` is 0 and the block is idle, no frame starts. `txd` stays 1, `tx_busy` stays 0, and the buffered byte is kept until enable returns.
- R10: If a write lands in the same cycle that the buffer hands its byte to the shifter, the old byte is sent, the new byte stays buffered, and `buf_empty` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; gates the baud tick |
| len7 | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| par_en | input | 1 | 1 = append parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop2 | input | 1 | 1 = two stop bits, 0 = one |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready (always 1) |
| wr_data | input | 8 | Byte to transmit |
| buf_empty | output | 1 | Holding buffer is empty |
| tx_busy | output | 1 | A frame is on the line |
| txd | output | 1 | Serial output, idle high |

## Verification
The buffer hand-off to the shifter and a new write into the buffer can fall in the same cycle. To provoke this, the bench stops the free-running tick and loads a byte while the block is idle. It then raises a single manual tick in the same cycle as a second write. It judges the outcome by three observations: `buf_empty` stays 0 after that edge, `txd` shows the start bit at once, and the two frames that follow carry the first byte and then the second byte back to back, with `tx_busy` never dropping between them.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic len7;
    logic par_en;
    logic par_odd;
    logic stop2;
  } frame_cfg_t;

endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              wr_ready,
  output logic              full,
  output logic [DATA_W-1:0] held
);

  // Never stalls the writer: a write while full replaces the byte.
  assign wr_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else begin
      if (wr_valid) begin
        // A write in the hand-off cycle wins: the old byte leaves, the new one stays.
        full <= 1'b1;
        held <= wr_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sertx_bitpace.sv
module sertx_bitpace #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic restart,
  output logic bit_end
);

  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt;

  assign bit_end = tick && run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (tick && run) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bit_end,
  input  frame_cfg_t        cfg,
  input  logic              have_byte,
  input  logic [DATA_W-1:0] byte_in,
  output logic              take,
  output logic              run,
  output logic              txd
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] IDX_FULL  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(DATA_W - 2);

  tx_state_e         state;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;
  logic              par_acc;
  logic              stop_seen;
  logic              last_stop;
  logic [IDX_W-1:0]  idx_last;

  assign idx_last  = cfg_q.len7 ? IDX_SHORT : IDX_FULL;
  assign last_stop = !(cfg_q.stop2 && !stop_seen);
  assign run       = (state != ST_IDLE);

  // Hand-off happens on the tick that starts the start bit.
  always_comb begin
    take = 1'b0;
    if (state == ST_IDLE && have_byte && tick)
      take = 1'b1;
    else if (state == ST_STOP && bit_end && last_stop && have_byte)
      take = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cfg_q     <= '0;
      shreg     <= '0;
      idx       <= '0;
      par_acc   <= 1'b0;
      stop_seen <= 1'b0;
      txd       <= 1'b1;
    end else if (take) begin
      state     <= ST_START;
      cfg_q     <= cfg;
      shreg     <= byte_in;
      idx       <= '0;
      par_acc   <= cfg.par_odd;
      stop_seen <= 1'b0;
      txd       <= 1'b0;
    end else if (bit_end) begin
      unique case (state)
        ST_START: begin
          state   <= ST_DATA;
          txd     <= shreg[0];
          par_acc <= par_acc ^ shreg[0];
          shreg   <= shreg >> 1;
          idx     <= '0;
        end
        ST_DATA: begin
          if (idx == idx_last) begin
            if (cfg_q.par_en) begin
              state <= ST_PAR;
              txd   <= par_acc;
            end else begin
              state <= ST_STOP;
              txd   <= 1'b1;
            end
          end else begin
            idx     <= idx + 1'b1;
            txd     <= shreg[0];
            par_acc <= par_acc ^ shreg[0];
            shreg   <= shreg >> 1;
          end
        end
        ST_PAR: begin
          state <= ST_STOP;
          txd   <= 1'b1;
        end
        ST_STOP: begin
          if (last_stop) begin
            state <= ST_IDLE;
            txd   <= 1'b1;
          end else begin
            stop_seen <= 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          txd   <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              len7,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop2,
  input  logic              baud_tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              buf_empty,
  output logic              tx_busy,
  output logic              txd
);

  logic              tick_g;
  logic              take;
  logic              full;
  logic [DATA_W-1:0] held;
  logic              run;
  logic              bit_end;
  frame_cfg_t        cfg;

  assign tick_g      = baud_tick & tx_en;
  assign cfg.len7    = len7;
  assign cfg.par_en  = par_en;
  assign cfg.par_odd = par_odd;
  assign cfg.stop2   = stop2;

  sertx_holdbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .take(take), .wr_ready(wr_ready), .full(full), .held(held)
  );

  sertx_bitpace #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_pace (
    .clk(clk), .rst_n(rst_n), .tick(tick_g), .run(run),
    .restart(take), .bit_end(bit_end)
  );

  sertx_framer #(.DATA_W(DATA_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .tick(tick_g), .bit_end(bit_end), .cfg(cfg),
    .have_byte(full), .byte_in(held), .take(take), .run(run), .txd(txd)
  );

  assign buf_empty = !full;
  assign tx_busy   = run;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic baud_tick,
  input logic wr_valid,
  input logic buf_empty,
  input logic tx_busy,
  input logic txd
);

  assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !buf_empty);

  assert_handoff_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> (!txd && tx_busy));

  assert_line_moves_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd));

  assert_idle_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  assert_busy_rise_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);

  assert_disabled_stays_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !tx_busy) |=> !tx_busy);

endmodule

bind sertx_top sertx_checker u_sertx_checker (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
  .wr_valid(wr_valid), .buf_empty(buf_empty), .tx_busy(tx_busy), .txd(txd)
);

// File: tb/test_sertx_top.sv
module test_sertx_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, len7 = 1'b0, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_ready, buf_empty, tx_busy, txd;
  logic baud_tick;

  logic auto_tick = 1'b1;
  logic man_tick = 1'b0;
  logic [1:0] tcnt = '0;
  logic auto_pulse = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  bit watch_gap = 0;
  int gap_cnt = 0;
  int low_cnt = 0;
  bit watch_low = 0;

  always #5 clk = ~clk;

  // Baud tick every 4 clocks, driven away from the active edge.
  always @(negedge clk) begin
    tcnt <= tcnt + 2'd1;
    auto_pulse <= auto_tick && (tcnt == 2'd3);
  end
  assign baud_tick = auto_pulse | man_tick;

  always @(negedge clk) begin
    if (watch_gap && !tx_busy) gap_cnt++;
    if (watch_low && !txd) low_cnt++;
  end

  sertx_top i_sertx_top (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .len7(len7), .par_en(par_en),
    .par_odd(par_odd), .stop2(stop2), .baud_tick(baud_tick),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .buf_empty(buf_empty), .tx_busy(tx_busy), .txd(txd)
  );

  // Vector: [15:12] frame length, [11] stop2, [10] par_odd, [9] par_en, [8] len7, [7:0] byte
  localparam logic [15:0] VEC [7] = '{
    {4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55},
    {4'd11, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA3},
    {4'd12, 1'b1, 1'b1, 1'b1, 1'b0, 8'hA3},
    {4'd9,  1'b0, 1'b0, 1'b0, 1'b1, 8'hF0},
    {4'd11, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81},
    {4'd11, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
    {4'd11, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Builds the expected line bits from the frame rules (R4..R7).
  function automatic int build_frame(input logic [7:0] d, input bit l7, input bit pe,
                                     input bit po, input bit s2, output logic [15:0] bits);
    int n = 0;
    int nd = l7 ? 7 : 8;
    logic p = po;
    bits = '1;
    bits[n] = 1'b0; n++;
    for (int i = 0; i < nd; i++) begin
      bits[n] = d[i]; p = p ^ d[i]; n++;
    end
    if (pe) begin bits[n] = p; n++; end
    bits[n] = 1'b1; n++;
    if (s2) begin bits[n] = 1'b1; n++; end
    return n;
  endfunction

  task automatic set_cfg(input bit l7, input bit pe, input bit po, input bit s2);
    @(negedge clk);
    len7 = l7; par_en = pe; par_odd = po; stop2 = s2;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // lead < 0: search for the start edge; otherwise wait lead cycles to the first mid-bit.
  task automatic capture(input int n, input int lead, output logic [15:0] bits,
                         output bit empty_at_start);
    bits = '1;
    empty_at_start = 1'b0;
    if (lead < 0) begin
      while (txd !== 1'b0) @(negedge clk);
      empty_at_start = buf_empty;
      repeat (31) @(negedge clk);
    end else begin
      repeat (lead) @(negedge clk);
    end
    for (int i = 0; i < n; i++) begin
      if (i != 0) repeat (64) @(negedge clk);
      bits[i] = txd;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] got, exp_b, got2, exp2;
    bit emp;
    int n, n2;

    repeat (3) @(negedge clk);
    // R1: reset values
    check(txd === 1'b1 && buf_empty === 1'b1 && tx_busy === 1'b0 && wr_ready === 1'b1,
          "R1 reset", {txd, buf_empty, tx_busy, wr_ready}, 4'b1101);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    tx_en = 1'b1;

    // Table walk: single frames, several formats (R3 R4 R5 R6 R7 R8)
    for (int v = 0; v < 7; v++) begin
      set_cfg(VEC[v][8], VEC[v][9], VEC[v][10], VEC[v][11]);
      n = build_frame(VEC[v][7:0], VEC[v][8], VEC[v][9], VEC[v][10], VEC[v][11], exp_b);
      check(n == int'(VEC[v][15:12]), "R7 frame length", n, VEC[v][15:12]);
      do_write(VEC[v][7:0]);
      check(buf_empty === 1'b0, "R2 write fills buffer", buf_empty, 0);
      capture(n, -1, got, emp);
      check(emp === 1'b1, "R3 buffer empties at start bit", emp, 1);
      check(got == exp_b, "R4 R5 R6 frame bits", got, exp_b);
      repeat (64) @(negedge clk);
      check(tx_busy === 1'b0 && txd === 1'b1, "R8 idle after frame", {tx_busy, txd}, 2'b01);
    end

    // R5: bit 7 ignored in 7-bit mode, including parity
    set_cfg(1'b1, 1'b1, 1'b0, 1'b0);
    n = build_frame(8'h12, 1'b1, 1'b1, 1'b0, 1'b0, exp_b);
    do_write(8'h92);
    capture(n, -1, got, emp);
    check(got == exp_b, "R5 bit7 ignored", got, exp_b);
    repeat (80) @(negedge clk);

    // R8: back to back, no gap, busy held
    set_cfg(1'b0, 1'b1, 1'b1, 1'b0);
    n = build_frame(8'h3C, 1'b0, 1'b1, 1'b1, 1'b0, exp_b);
    n2 = build_frame(8'hC5, 1'b0, 1'b1, 1'b1, 1'b0, exp2);
    do_write(8'h3C);
    while (buf_empty !== 1'b1) @(negedge clk);
    watch_gap = 1; gap_cnt = 0;
    do_write(8'hC5);
    capture(n, 0, got, emp);
    check(got[n-1] === 1'b1, "R8 first frame stop", got[n-1], 1);
    capture(n2, 64, got2, emp);
    check(got2 == exp2, "R8 second frame follows directly", got2, exp2);
    watch_gap = 0;
    check(gap_cnt == 0, "R8 busy continuous", gap_cnt, 0);
    repeat (80) @(negedge clk);

    // R2: overwrite while full, frame on line unchanged
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
    n = build_frame(8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, exp_b);
    n2 = build_frame(8'hE7, 1'b0, 1'b0, 1'b0, 1'b0, exp2);
    do_write(8'h0F);
    while (buf_empty !== 1'b1) @(negedge clk);
    do_write(8'h99);
    do_write(8'hE7);
    capture(n, 0, got, emp);
    check(got[n-1] === 1'b1, "R2 line frame intact stop", got[n-1], 1);
    capture(n2, 64, got2, emp);
    check(got2 == exp2, "R2 overwrite keeps latest", got2, exp2);
    repeat (100) @(negedge clk);
    check(tx_busy === 1'b0 && buf_empty === 1'b1, "R2 no extra frame",
          {tx_busy, buf_empty}, 2'b01);

    // R9: disabled, nothing moves
    tx_en = 1'b0;
    n = build_frame(8'h6B, 1'b0, 1'b0, 1'b0, 1'b0, exp_b);
    do_write(8'h6B);
    watch_low = 1; low_cnt = 0;
    repeat (800) @(negedge clk);
    watch_low = 0;
    check(low_cnt == 0 && tx_busy === 1'b0, "R9 line idle while disabled", low_cnt, 0);
    check(buf_empty === 1'b0, "R9 byte kept", buf_empty, 0);
    tx_en = 1'b1;
    capture(n, -1, got, emp);
    check(got == exp_b, "R9 held byte sent after enable", got, exp_b);
    repeat (80) @(negedge clk);

    // R10: write in the hand-off cycle
    auto_tick = 1'b0;
    repeat (4) @(negedge clk);
    n = build_frame(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, exp_b);
    n2 = build_frame(8'h3E, 1'b0, 1'b0, 1'b0, 1'b0, exp2);
    do_write(8'hA5);
    check(tx_busy === 1'b0 && txd === 1'b1, "R3 no start without tick", {tx_busy, txd}, 2'b01);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'h3E; man_tick = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; man_tick = 1'b0;
    check(buf_empty === 1'b0, "R10 buffer stays full", buf_empty, 0);
    check(txd === 1'b0 && tx_busy === 1'b1, "R10 start bit at hand-off", {txd, tx_busy}, 2'b01);
    auto_tick = 1'b1;
    watch_gap = 1; gap_cnt = 0;
    capture(n, 31, got, emp);
    check(got == exp_b, "R10 old byte sent", got, exp_b);
    capture(n2, 64, got2, emp);
    check(got2 == exp2, "R10 new byte follows", got2, exp2);
    watch_gap = 0;
    check(gap_cnt == 0, "R10 busy continuous", gap_cnt, 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule